// File: doc/BRIEF.md
# Debounced Two-Button Step Generator with Hold Repeat

This block turns two active-low push buttons, one meaning "up" and one meaning "down", into clean single-cycle step commands for a downstream position counter. Each raw input first passes through a two-flop synchronizer. It must then stay pressed for a debounce window before it counts as a press. A confirmed press issues one step at once. If the button is kept down, further steps follow at a slow interval. After a programmable hold time, the steps switch to a faster interval.

All timing is counted in ticks of a one-cycle `tick_ms` enable, normally pulsed once per millisecond. The debounce, slow, fast, hold and release-gap lengths are therefore parameters in milliseconds. When both buttons are down together, the block issues no step and raises a flag for the downstream logic. Nothing new is accepted until both buttons have been let go. After every release, the block waits a short gap before it accepts another press.

Top module: `btn_repeat_gen`

## Requirements
- R1: A button whose synchronized level stays pressed for fewer than DB_TICKS ticks produces no step.
- R2: Each input passes through two flops. Once the synchronized level has stayed pressed through DB_TICKS ticks, exactly one step for that button is issued in the cycle after the completing tick.
- R3: While the button stays held and fewer than HOLD_TICKS ticks have passed since the first step, further steps follow every SLOW_TICKS ticks.
- R4: Once HOLD_TICKS ticks have passed since the first step, the repeat interval becomes FAST_TICKS ticks. It counts from the last step and stays fast until release.
- R5: When the synchronized level of the held button is released, stepping stops at once. A step is only issued while its button's synchronized level is pressed.
- R6: While both synchronized inputs are pressed, `both_held` is 1 and no step is issued. Afterwards no step is issued until both buttons have been released.
- R7: After a release, or after leaving the both-pressed condition, GAP_TICKS ticks must elapse before a new press begins its debounce.
- R8: `step_up` and `step_down` are pulses aligned to a tick, and they are never 1 in the same cycle.
- R9: During and right after reset, `step_up`, `step_down` and `both_held` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle timebase enable, one per time unit |
| btn_up_n | input | 1 | Raw up button, 0 = pressed |
| btn_dn_n | input | 1 | Raw down button, 0 = pressed |
| step_up | output | 1 | One-cycle increment command |
| step_down | output | 1 | One-cycle decrement command |
| both_held | output | 1 | Both synchronized inputs pressed |

## Verification
The bench builds the block with DB_TICKS=3, SLOW_TICKS=5, FAST_TICKS=2, HOLD_TICKS=12 and GAP_TICKS=2, and drives a tick every fourth clock. With these values, a held press passes from the first step through the slow phase and into the fast phase within about 140 clocks. That lets the bench measure both repeat intervals directly. The short values also make it practical to place a press just inside or just outside the debounce window, and inside the release gap.

// File: rtl/btn_repeat_gen.sv
module btn_repeat_gen #(
  parameter int DB_TICKS   = 15,
  parameter int SLOW_TICKS = 100,
  parameter int FAST_TICKS = 25,
  parameter int HOLD_TICKS = 1000,
  parameter int GAP_TICKS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic btn_up_n,
  input  logic btn_dn_n,
  output logic step_up,
  output logic step_down,
  output logic both_held
);
  localparam int CW = $clog2(DB_TICKS + SLOW_TICKS + FAST_TICKS + GAP_TICKS + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEB, S_HELD, S_GAP, S_BLOCK} st_t;

  logic up_m, up_s, dn_m, dn_s;
  st_t state;
  logic dir_up;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold;

  wire both = up_s & dn_s;
  wire act  = dir_up ? up_s : dn_s;
  wire fast = (hold >= HW'(HOLD_TICKS));
  wire [CW-1:0] per = fast ? CW'(FAST_TICKS) : CW'(SLOW_TICKS);

  assign both_held = both;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_m <= 1'b0; up_s <= 1'b0;
      dn_m <= 1'b0; dn_s <= 1'b0;
    end else begin
      up_m <= ~btn_up_n; up_s <= up_m;
      dn_m <= ~btn_dn_n; dn_s <= dn_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      dir_up    <= 1'b0;
      cnt       <= '0;
      hold      <= '0;
      step_up   <= 1'b0;
      step_down <= 1'b0;
    end else begin
      step_up   <= 1'b0;
      step_down <= 1'b0;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (both) state <= S_BLOCK;
          else if (up_s) begin dir_up <= 1'b1; state <= S_DEB; end
          else if (dn_s) begin dir_up <= 1'b0; state <= S_DEB; end
        end
        S_DEB: begin
          if (both) state <= S_BLOCK;
          else if (!act) state <= S_IDLE;
          else if (tick_ms) begin
            if (cnt == CW'(DB_TICKS - 1)) begin
              state     <= S_HELD;
              cnt       <= '0;
              hold      <= '0;
              step_up   <= dir_up;
              step_down <= ~dir_up;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_HELD: begin
          if (both) state <= S_BLOCK;
          else if (!act) begin state <= S_GAP; cnt <= '0; end
          else if (tick_ms) begin
            if (!fast) hold <= hold + 1'b1;
            if (cnt >= per - 1'b1) begin
              cnt       <= '0;
              step_up   <= dir_up;
              step_down <= ~dir_up;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (both) state <= S_BLOCK;
          else if (tick_ms) begin
            if (cnt == CW'(GAP_TICKS - 1)) state <= S_IDLE;
            else cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt <= '0;
          if (!up_s && !dn_s) state <= S_GAP;
        end
      endcase
    end
  end
endmodule

module btn_repeat_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_ms,
  input logic btn_up_n,
  input logic btn_dn_n,
  input logic step_up,
  input logic step_down,
  input logic both_held
);
  a_r8_never_both_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_down));
  a_r8_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_down) |-> $past(tick_ms));
  a_r6_no_step_after_both: assert property (@(posedge clk) disable iff (!rst_n)
    both_held |=> !(step_up || step_down));
  a_r5_up_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> ($past(btn_up_n, 3) == 1'b0));
  a_r5_dn_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
    step_down |-> ($past(btn_dn_n, 3) == 1'b0));
endmodule

bind btn_repeat_gen btn_repeat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_up_n(btn_up_n),
  .btn_dn_n(btn_dn_n), .step_up(step_up), .step_down(step_down),
  .both_held(both_held)
);

// File: tb/sim_btn_repeat_gen.sv
module sim_btn_repeat_gen;
  localparam int TCLK = 10;
  localparam int TDIV = 4;
  localparam int DB = 3, SLOW = 5, FAST = 2, HOLD = 12, GAP = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0;
  logic btn_up_n = 1'b1, btn_dn_n = 1'b1;
  logic step_up, step_down, both_held;

  btn_repeat_gen #(.DB_TICKS(DB), .SLOW_TICKS(SLOW), .FAST_TICKS(FAST),
                   .HOLD_TICKS(HOLD), .GAP_TICKS(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_up_n(btn_up_n),
    .btn_dn_n(btn_dn_n), .step_up(step_up), .step_down(step_down),
    .both_held(both_held));

  always #(TCLK/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tdiv = 0;
  string cur_req = "R9";
  bit done = 0;

  // reference model state
  bit m1u, m2u, m1d, m2d, eu, ed, eb;
  int mode = 0, age = 0, last = 0, gapc = 0;
  bit dirU = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1u = 0; m2u = 0; m1d = 0; m2d = 0; eu = 0; ed = 0; eb = 0;
      mode = 0; age = 0; last = 0; gapc = 0; dirU = 0;
    end else begin
      bit both, act, stp;
      int ivl;
      both = m2u && m2d;
      act = dirU ? m2u : m2d;
      stp = 0;
      case (mode)
        0: if (both) mode = 4;
           else if (m2u) begin dirU = 1; mode = 1; age = 0; end
           else if (m2d) begin dirU = 0; mode = 1; age = 0; end
        1: if (both) mode = 4;
           else if (!act) mode = 0;
           else if (tick_ms) begin
             age++;
             if (age == DB) begin stp = 1; mode = 2; last = age; end
           end
        2: if (both) mode = 4;
           else if (!act) begin mode = 3; gapc = 0; end
           else if (tick_ms) begin
             ivl = (age - DB >= HOLD) ? FAST : SLOW;
             age++;
             if (age - last >= ivl) begin stp = 1; last = age; end
           end
        3: if (both) mode = 4;
           else if (tick_ms) begin gapc++; if (gapc == GAP) mode = 0; end
        default: if (!m2u && !m2d) begin mode = 3; gapc = 0; end
      endcase
      eu = stp && dirU;
      ed = stp && !dirU;
      m2u = m1u; m1u = !btn_up_n;
      m2d = m1d; m1d = !btn_dn_n;
      eb = m2u && m2d;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  int n_up = 0, n_dn = 0, n_dual = 0, n_bh = 0;
  int t_up[$];

  always @(negedge clk) begin
    cyc++;
    tdiv = (tdiv + 1) % TDIV;
    tick_ms <= (tdiv == 0);
    if (rst_n) begin
      chk(cur_req, step_up, eu, "step_up vs model");
      chk(cur_req, step_down, ed, "step_down vs model");
      chk(cur_req, both_held, eb, "both_held vs model");
      if (step_up) begin n_up++; t_up.push_back(cyc); end
      if (step_down) n_dn++;
      if (step_up && step_down) n_dual++;
      if (both_held) n_bh++;
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    n_up = 0; n_dn = 0; n_dual = 0; n_bh = 0; t_up.delete();
  endtask

  initial begin
    wait_clk(3);
    chk("R9", step_up, 0, "step_up in reset");
    chk("R9", step_down, 0, "step_down in reset");
    chk("R9", both_held, 0, "both_held in reset");
    rst_n = 1'b1;
    wait_clk(1);
    chk("R9", step_up | step_down | both_held, 0, "outputs after reset");
    wait_clk(10);

    // R1: short press rejected
    cur_req = "R1"; clr();
    btn_up_n = 0; wait_clk(8); btn_up_n = 1; wait_clk(40);
    chk("R1", n_up + n_dn, 0, "steps from bounce");

    // R2: press just past debounce gives one step
    cur_req = "R2"; clr();
    btn_dn_n = 0; wait_clk(16); btn_dn_n = 1; wait_clk(40);
    chk("R2", n_dn, 1, "down steps for one press");
    chk("R2", n_up, 0, "up steps for down press");

    // R3/R4: long hold, slow then fast
    cur_req = "R4"; clr();
    btn_up_n = 0; wait_clk(140);
    btn_up_n = 1; wait_clk(3);
    chk("R4", (n_up >= 6) ? 1 : 0, 1, "enough steps in long hold");
    if (t_up.size() >= 3) begin
      chk("R3", t_up[1] - t_up[0], SLOW * TDIV, "first repeat interval clocks");
      chk("R4", t_up[t_up.size()-1] - t_up[t_up.size()-2], FAST * TDIV,
          "final repeat interval clocks");
    end
    chk("R8", n_dual, 0, "cycles with both steps");

    // R5: nothing after release
    cur_req = "R5"; clr();
    wait_clk(60);
    chk("R5", n_up + n_dn, 0, "steps after release");

    // R6: both pressed, then partial release
    cur_req = "R6"; clr();
    btn_up_n = 0; btn_dn_n = 0; wait_clk(60);
    chk("R6", (n_bh > 0) ? 1 : 0, 1, "both_held seen");
    btn_dn_n = 1; wait_clk(40);
    chk("R6", n_up + n_dn, 0, "steps while blocked");
    btn_up_n = 1; wait_clk(30);
    chk("R6", both_held, 0, "both_held after release");

    // R7: press during release gap is delayed
    cur_req = "R7"; clr();
    btn_up_n = 0; wait_clk(16); btn_up_n = 1; wait_clk(1);
    btn_up_n = 0; wait_clk(12); btn_up_n = 1; wait_clk(40);
    chk("R7", n_up, 1, "steps for press plus press inside gap");

    // R2 again: the same press after the gap does count
    cur_req = "R2"; clr();
    btn_up_n = 0; wait_clk(16); btn_up_n = 1; wait_clk(40);
    chk("R2", n_up, 1, "press after gap");

    done = 1;
    finish_run();
  end
endmodule